// File: doc/BRIEF.md
# Oscillator Delay-Stage Search Controller

This controller sits between a time-to-digital converter and a digitally controlled oscillator built from a coarse delay line and a fine delay line. Each measurement gives two things: a pulse count, which is the size of the phase error, and a direction flag. From these the controller picks how many coarse stages and how many fine stages the oscillator should use. It drives a one-hot select for each line to the stage transmission gates. It also drives a thermometer of power-header enables, so that delay cells outside the active path lose their supply.

The search uses a binary search with two changes. The first measurement after reset or a relock request places the coarse index away from mid-range, by an amount scaled from the count. Each later step is sized from the newest count rather than halved. When the coarse error falls below one coarse step, the search moves to the fine line. Two fine measurements in a row within a programmable tolerance declare lock. While locked the codes are frozen and measurements are ignored until a relock request arrives.

Top module: `dco_code_search`

## Requirements
- R1: After reset, the coarse index and the fine index are both at MID = N/2 (6 for 12 stages), and `locked` is low.
- R2: The first measurement after reset or relock moves the coarse index from MID by `pulseCount >> (COARSE_SHIFT-1)` (default shift 4, so count/8). It adds stages when `lagFlag` is 0 and removes them when `lagFlag` is 1.
- R3: During the coarse search, a measurement with `pulseCount >> COARSE_SHIFT` nonzero moves the coarse index by that amount, in the direction given by `lagFlag` as in R2.
- R4: During the coarse search, a measurement with `pulseCount >> COARSE_SHIFT` equal to zero leaves the coarse index unchanged and starts the fine search, with the fine index at MID.
- R5: During the fine search, a measurement with `pulseCount` greater than `tolerance` moves the fine index by `max(1, pulseCount >> FINE_SHIFT)` (default shift 1), in the direction given by `lagFlag`. A measurement with `pulseCount` at or below `tolerance` leaves the index unchanged.
- R6: Every move saturates: an index never goes below 0 or above N-1.
- R7: `coarseSel` and `fineSel` each have exactly one bit set, at bit position equal to the index.
- R8: `coarseHdr` and `fineHdr` have bits 0 up to and including the index set, and all higher bits clear.
- R9: `locked` rises after two consecutive fine measurements within tolerance. An out-of-tolerance fine measurement restarts that count.
- R10: While locked, measurements change neither the codes nor `locked`.
- R11: `relockReq` clears `locked`, returns both indices to MID and restarts the search at R2. When `relockReq` and `measValid` are high in the same cycle, the request wins and the measurement is dropped.
- R12: Without `measValid` or `relockReq`, all outputs hold. Every update appears on the clock edge after the sampled input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| measValid | input | 1 | Qualifies one measurement for one cycle |
| pulseCount | input | 9 | Phase error magnitude in oscillator pulses |
| lagFlag | input | 1 | 1: oscillator slow, remove stages; 0: add stages |
| tolerance | input | 9 | Largest count that counts as in lock |
| relockReq | input | 1 | Restart the search from mid-range |
| coarseSel | output | 12 | One-hot coarse stage select |
| fineSel | output | 12 | One-hot fine stage select |
| coarseHdr | output | 12 | Coarse header enables, thermometer |
| fineHdr | output | 12 | Fine header enables, thermometer |
| locked | output | 1 | Search has converged; codes frozen |

## Verification
A relock request and a measurement can both arrive in the same cycle, either while locked or during a search. Either one alone would move the codes, so the order between them matters. The bench raises both strobes together while locked, with a large count that would move the index if it were taken. It expects both indices back at mid-range and `locked` low. It then sends the next measurement and expects it to be treated as the first placement of a fresh search, which shows the dropped measurement left no trace.

// File: rtl/dco_search_pkg.sv
package dco_search_pkg;

  typedef enum logic [1:0] {
    ST_START  = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_LOCK   = 2'd3
  } searchState_t;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic restart;
    logic startCoarse;
    logic stepCoarse;
    logic enterFine;
    logic stepFine;
  } pathStrobe_t;

endpackage

// File: rtl/dco_search_ctrl.sv
module dco_search_ctrl
  import dco_search_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int COARSE_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             measValid,
  input  logic [CNT_W-1:0] pulseCount,
  input  logic [CNT_W-1:0] tolerance,
  input  logic             relockReq,
  output pathStrobe_t      strobe,
  output logic             locked
);

  searchState_t state, stateNext;
  logic         goodSeen, goodSeenNext;
  logic         coarseSmall;
  logic         inTol;

  assign coarseSmall = (pulseCount >> COARSE_SHIFT) == '0;
  assign inTol       = pulseCount <= tolerance;

  always_comb begin
    strobe       = '0;
    stateNext    = state;
    goodSeenNext = goodSeen;
    if (relockReq) begin
      strobe.restart = 1'b1;
      stateNext      = ST_START;
      goodSeenNext   = 1'b0;
    end else if (measValid) begin
      unique case (state)
        ST_START: begin
          strobe.startCoarse = 1'b1;
          stateNext          = ST_COARSE;
        end
        ST_COARSE: begin
          if (coarseSmall) begin
            strobe.enterFine = 1'b1;
            stateNext        = ST_FINE;
            goodSeenNext     = 1'b0;
          end else begin
            strobe.stepCoarse = 1'b1;
          end
        end
        ST_FINE: begin
          if (inTol) begin
            if (goodSeen) stateNext = ST_LOCK;
            goodSeenNext = 1'b1;
          end else begin
            strobe.stepFine = 1'b1;
            goodSeenNext    = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_START;
      goodSeen <= 1'b0;
    end else begin
      state    <= stateNext;
      goodSeen <= goodSeenNext;
    end
  end

  assign locked = (state == ST_LOCK);

  // R9: lock is only entered from the fine search
  p_lock_from_fine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state) == ST_FINE);

  // R9: lock needs a prior in-tolerance fine measurement
  p_lock_two_good_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(goodSeen));

  // R10: nothing but relock leaves lock
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !relockReq |=> locked);

  // strobes are mutually exclusive
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

endmodule

// File: rtl/dco_stage_decode.sv
module dco_stage_decode #(
  parameter int N   = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  sel,
  output logic [N-1:0]  hdr
);

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign sel[i] = (idx == IW'(i));
    assign hdr[i] = (IW'(i) <= idx);
  end

endmodule

// File: rtl/dco_search_path.sv
module dco_search_path
  import dco_search_pkg::*;
#(
  parameter int NUM_COARSE   = 12,
  parameter int NUM_FINE     = 12,
  parameter int CNT_W        = 9,
  parameter int COARSE_SHIFT = 4,
  parameter int FINE_SHIFT   = 1,
  localparam int CIW = $clog2(NUM_COARSE),
  localparam int FIW = $clog2(NUM_FINE),
  localparam int SW  = CNT_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pathStrobe_t           strobe,
  input  logic [CNT_W-1:0]      pulseCount,
  input  logic                  lagFlag,
  output logic [NUM_COARSE-1:0] coarseSel,
  output logic [NUM_FINE-1:0]   fineSel,
  output logic [NUM_COARSE-1:0] coarseHdr,
  output logic [NUM_FINE-1:0]   fineHdr
);

  localparam logic [CIW-1:0] C_MID = CIW'(NUM_COARSE / 2);
  localparam logic [FIW-1:0] F_MID = FIW'(NUM_FINE / 2);
  localparam logic [SW-1:0]  C_TOP = SW'(NUM_COARSE - 1);
  localparam logic [SW-1:0]  F_TOP = SW'(NUM_FINE - 1);

  logic [CIW-1:0]   coarseIdx;
  logic [FIW-1:0]   fineIdx;
  logic [SW-1:0]    startStep, coarseStep, fineStep;
  logic [CNT_W-1:0] fineRaw;
  logic [SW-1:0]    startTarget, coarseTarget, fineTarget;

  function automatic logic [SW-1:0] moveIdx(input logic [SW-1:0] cur,
                                            input logic [SW-1:0] step,
                                            input logic          down,
                                            input logic [SW-1:0] top);
    logic [SW-1:0] sum;
    sum = cur + step;
    if (down) return (step > cur) ? '0 : cur - step;
    return (sum > top) ? top : sum;
  endfunction

  assign startStep  = {2'b00, pulseCount >> (COARSE_SHIFT - 1)};
  assign coarseStep = {2'b00, pulseCount >> COARSE_SHIFT};
  assign fineRaw    = pulseCount >> FINE_SHIFT;
  assign fineStep   = (fineRaw == '0) ? SW'(1) : {2'b00, fineRaw};

  assign startTarget  = moveIdx(SW'(C_MID), startStep, lagFlag, C_TOP);
  assign coarseTarget = moveIdx(SW'(coarseIdx), coarseStep, lagFlag, C_TOP);
  assign fineTarget   = moveIdx(SW'(fineIdx), fineStep, lagFlag, F_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarseIdx <= C_MID;
      fineIdx   <= F_MID;
    end else begin
      if (strobe.restart) begin
        coarseIdx <= C_MID;
        fineIdx   <= F_MID;
      end
      if (strobe.startCoarse) coarseIdx <= CIW'(startTarget);
      if (strobe.stepCoarse)  coarseIdx <= CIW'(coarseTarget);
      if (strobe.enterFine)   fineIdx   <= F_MID;
      if (strobe.stepFine)    fineIdx   <= FIW'(fineTarget);
    end
  end

  dco_stage_decode #(.N(NUM_COARSE)) u_coarseDec (
    .idx(coarseIdx), .sel(coarseSel), .hdr(coarseHdr));

  dco_stage_decode #(.N(NUM_FINE)) u_fineDec (
    .idx(fineIdx), .sel(fineSel), .hdr(fineHdr));

  // R6: saturation keeps indices in range
  p_coarse_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(coarseIdx) < NUM_COARSE);
  p_fine_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fineIdx) < NUM_FINE);

  // R5: direction of a fine step follows the flag
  p_fine_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepFine && !lagFlag |=> fineIdx >= $past(fineIdx));
  p_fine_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepFine && lagFlag |=> fineIdx <= $past(fineIdx));

  // R4: entering the fine search leaves the coarse code alone
  p_enter_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enterFine |=> $stable(coarseIdx));

endmodule

// File: rtl/dco_code_search.sv
module dco_code_search
  import dco_search_pkg::*;
#(
  parameter int NUM_COARSE   = 12,
  parameter int NUM_FINE     = 12,
  parameter int CNT_W        = 9,
  parameter int COARSE_SHIFT = 4,
  parameter int FINE_SHIFT   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  measValid,
  input  logic [CNT_W-1:0]      pulseCount,
  input  logic                  lagFlag,
  input  logic [CNT_W-1:0]      tolerance,
  input  logic                  relockReq,
  output logic [NUM_COARSE-1:0] coarseSel,
  output logic [NUM_FINE-1:0]   fineSel,
  output logic [NUM_COARSE-1:0] coarseHdr,
  output logic [NUM_FINE-1:0]   fineHdr,
  output logic                  locked
);

  pathStrobe_t strobe;

  dco_search_ctrl #(.CNT_W(CNT_W), .COARSE_SHIFT(COARSE_SHIFT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .measValid(measValid), .pulseCount(pulseCount),
    .tolerance(tolerance), .relockReq(relockReq), .strobe(strobe),
    .locked(locked));

  dco_search_path #(
    .NUM_COARSE(NUM_COARSE), .NUM_FINE(NUM_FINE), .CNT_W(CNT_W),
    .COARSE_SHIFT(COARSE_SHIFT), .FINE_SHIFT(FINE_SHIFT)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pulseCount(pulseCount),
    .lagFlag(lagFlag), .coarseSel(coarseSel), .fineSel(fineSel),
    .coarseHdr(coarseHdr), .fineHdr(fineHdr));

  // R7: exactly one stage selected on each line
  p_coarse_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(coarseSel) == 1);
  p_fine_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fineSel) == 1);

  // R8: header set equals the selected stage and every lower one
  p_coarse_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coarseHdr == ((coarseSel << 1) - NUM_COARSE'(1)));
  p_fine_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fineHdr == ((fineSel << 1) - NUM_FINE'(1)));

  // R10: codes frozen while locked
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !relockReq |=> $stable(coarseSel) && $stable(fineSel));

  // R11: relock always drops lock
  p_relock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    relockReq |=> !locked);

  // R12: no strobe, no change
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !measValid && !relockReq |=> $stable(coarseSel) && $stable(fineSel));

endmodule

// File: tb/dco_code_search_test.sv
`timescale 1ns/1ps
module dco_code_search_test;

  localparam int NC = 12;
  localparam int NF = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          measValid = 1'b0;
  logic [8:0]    pulseCount = '0;
  logic          lagFlag = 1'b0;
  logic [8:0]    tolerance = 9'd2;
  logic          relockReq = 1'b0;
  logic [NC-1:0] coarseSel, coarseHdr;
  logic [NF-1:0] fineSel, fineHdr;
  logic          locked;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dco_code_search uut (
    .clk(clk), .rst_n(rst_n), .measValid(measValid), .pulseCount(pulseCount),
    .lagFlag(lagFlag), .tolerance(tolerance), .relockReq(relockReq),
    .coarseSel(coarseSel), .fineSel(fineSel), .coarseHdr(coarseHdr),
    .fineHdr(fineHdr), .locked(locked));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected state from requirements R7/R8 encodings
  task automatic expectState(input string req, input int ec, input int ef,
                             input bit el);
    check(req, "coarseSel", 32'(coarseSel), 32'(1) << ec);
    check(req, "coarseHdr", 32'(coarseHdr), (32'(1) << (ec + 1)) - 1);
    check(req, "fineSel",   32'(fineSel),   32'(1) << ef);
    check(req, "fineHdr",   32'(fineHdr),   (32'(1) << (ef + 1)) - 1);
    check(req, "locked",    32'(locked),    32'(el));
  endtask

  task automatic measure(input int cnt, input bit lag, input bit relock);
    @(negedge clk);
    measValid  = 1'b1;
    pulseCount = 9'(cnt);
    lagFlag    = lag;
    relockReq  = relock;
    @(negedge clk);
    measValid  = 1'b0;
    relockReq  = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expectState("R1", 6, 6, 0);
  endtask

  task automatic t_idle();
    repeat (4) @(negedge clk);
    expectState("R12", 6, 6, 0);
  endtask

  task automatic t_start();
    measure(40, 0, 0);           // 40>>3 = 5, 6+5 = 11
    expectState("R2", 11, 6, 0);
  endtask

  task automatic t_coarse();
    measure(100, 0, 0);          // step 6, saturate at 11
    expectState("R6", 11, 6, 0);
    measure(200, 1, 0);          // step 12 down, saturate at 0
    expectState("R6", 0, 6, 0);
    measure(20, 0, 0);           // step 1 up
    expectState("R3", 1, 6, 0);
    measure(36, 0, 0);           // step 2 up
    expectState("R3", 3, 6, 0);
    measure(40, 1, 0);           // step 2 down
    expectState("R3", 1, 6, 0);
  endtask

  task automatic t_enter_fine();
    measure(10, 1, 0);           // 10>>4 = 0, coarse held, fine to mid
    expectState("R4", 1, 6, 0);
  endtask

  task automatic t_fine();
    measure(6, 1, 0);            // step 3 down
    expectState("R5", 1, 3, 0);
    measure(100, 0, 0);          // step 50 up, saturate at 11
    expectState("R6", 1, 11, 0);
    measure(3, 1, 0);            // above tolerance, step max(1,1) down
    expectState("R5", 1, 10, 0);
    measure(1, 0, 0);            // within tolerance, hold
    expectState("R5", 1, 10, 0);
    measure(5, 0, 0);            // breaks streak, step 2 up, saturate at 11
    expectState("R9", 1, 11, 0);
    measure(2, 0, 0);            // first good after break: no lock yet
    expectState("R9", 1, 11, 0);
    measure(0, 1, 0);            // second good in a row: lock
    expectState("R9", 1, 11, 1);
  endtask

  task automatic t_locked();
    measure(300, 1, 0);
    expectState("R10", 1, 11, 1);
    repeat (3) @(negedge clk);
    expectState("R10", 1, 11, 1);
  endtask

  task automatic t_relock_collide();
    measure(80, 0, 1);           // relock wins, measurement dropped
    expectState("R11", 6, 6, 0);
    measure(8, 1, 0);            // fresh first placement: 8>>3 = 1 down
    expectState("R11", 5, 6, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_start();
    t_coarse();
    t_enter_fine();
    t_fine();
    t_locked();
    t_relock_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule